// File: doc/BRIEF.md
# Stride-Detecting Data Prefetcher

This block sits beside a core's data cache and watches the demand load addresses the core issues. It keeps a small table of access streams, keyed by 4 KB page number. For each stream it learns the byte distance between successive accesses and how often that distance has repeated. Once a stream has repeated the same non-zero distance often enough, an access to it produces a prefetch request four distances ahead. While no stream in the table is trusted, every access instead produces a request for the cache line that follows the accessed line.

Every request is cut down to a 64-byte line address. A request whose target page differs from the page of the access that caused it is discarded. Surviving requests wait in a small queue and leave through a valid/ready port. When the queue is full, new requests are dropped. The demand side has no ready signal, so training never waits on the prefetch port.

Top module: `stride_prefetcher`

## Requirements
- R1: Every address presented on `pf_addr` while `pf_valid` is high has its low 6 bits equal to zero. The target is rounded down to its 64-byte line.
- R2: When no table entry is trusted, an accepted access to byte address A produces a request for (A rounded down to 64 bytes) + 64. A trusted entry is one that is valid, has confidence of at least 2 and holds a non-zero stride.
- R3: Each entry holds a last address, a stride and a 2-bit confidence. A new entry starts with stride 0 and confidence 0. On a hit, the new stride is A minus the last address, taken modulo 2^AW. Confidence goes up by one, saturating at 3, when the new stride equals the stored stride. Otherwise confidence goes to 0. The entry then stores A and the new stride.
- R4: When a hit leaves its entry with confidence of at least 2 and a non-zero stride, the request target is A + 4 × stride, rounded down to 64 bytes. This holds for negative strides and for strides smaller than a line.
- R5: A stride of zero never produces a stride request, whatever its confidence.
- R6: While at least one entry is trusted before the access, an access that does not itself meet R4 produces no request.
- R7: A request whose target bits [AW-1:12] differ from those of the triggering access is never issued.
- R8: The table tracks 4 pages at once. A miss allocates the entry named by a round-robin pointer, which starts at entry 0 after reset, and evicts that entry's earlier stream.
- R9: Requests leave in the order they were made, from a 4-deep queue. A request made while the queue holds 4 is dropped. `pf_valid` and `pf_addr` hold steady while `pf_ready` is low.
- R10: Stream training on accepted accesses goes on unchanged while the queue is full.
- R11: `rst_n` low at a clock edge (synchronous, active low) invalidates all entries, resets the round-robin pointer and empties the queue.
- R12: With an empty queue, a request appears on `pf_valid`/`pf_addr` in the cycle after the clock edge that accepted the access. No request is made in a cycle without `dmd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dmd_valid | input | 1 | A demand access is present this cycle |
| dmd_addr | input | AW (32) | Byte address of the demand access |
| pf_valid | output | 1 | A prefetch request is waiting |
| pf_ready | input | 1 | Consumer takes the request this cycle |
| pf_addr | output | AW (32) | Line-aligned prefetch target |

## Verification
The bench builds the block with its defaults: 32-bit addresses, 4 entries, 2-bit confidence with threshold 2, a look-ahead shift of 2 and a 4-deep queue. With these values, a stride of 0x200 reaches a page end after a handful of accesses, so page suppression of stride targets shows up naturally. Five page misses are enough to wrap the round-robin pointer and evict a trained stream. Six back-to-back requests overflow the queue.

// File: rtl/pf_pkg.sv
// Package: shared types for the stride prefetcher.
// Assumes: nothing beyond the importing modules' parameters.
package pf_pkg;
    // Source of a candidate request.
    typedef enum logic [1:0] {
        PFK_NONE   = 2'd0,
        PFK_NEXT   = 2'd1,
        PFK_STRIDE = 2'd2
    } pf_kind_e;
endpackage

// File: rtl/pf_stream_table.sv
// Stream table: a page-keyed set of stride trackers with confidence counters.
// Assumes: ENTRIES >= 2, a power of two is not required; one access per cycle at most.
module pf_stream_table #(
    parameter int AW       = 32,
    parameter int PAGE_W   = 12,
    parameter int ENTRIES  = 4,
    parameter int CONF_W   = 2,
    parameter int CONF_MIN = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic [AW-1:0] acc_addr,
    output logic          stride_ok,
    output logic [AW-1:0] stride_val,
    output logic          any_conf
);
    localparam int TAG_W = AW - PAGE_W;
    localparam int IDX_W = $clog2(ENTRIES);
    localparam logic [CONF_W-1:0] CONF_THR = CONF_W'(CONF_MIN);
    localparam logic [CONF_W-1:0] CONF_TOP = '1;

    logic              ent_valid  [ENTRIES];
    logic [TAG_W-1:0]  ent_tag    [ENTRIES];
    logic [AW-1:0]     ent_last   [ENTRIES];
    logic [AW-1:0]     ent_stride [ENTRIES];
    logic [CONF_W-1:0] ent_conf   [ENTRIES];
    logic [IDX_W-1:0]  rr_ptr;

    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] trust_vec;
    logic               hit_any;
    logic [IDX_W-1:0]   hit_idx;
    logic [AW-1:0]      new_stride;
    logic [CONF_W-1:0]  conf_next;
    logic [TAG_W-1:0]   acc_tag;

    assign acc_tag = acc_addr[AW-1:PAGE_W];

    // Per-entry page match and trust flags.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        assign hit_vec[g]   = ent_valid[g] && (ent_tag[g] == acc_tag);
        assign trust_vec[g] = ent_valid[g] && (ent_conf[g] >= CONF_THR)
                              && (ent_stride[g] != '0);
    end

    // Pick the hitting entry and compute its updated stride and confidence.
    always_comb begin
        hit_any = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i] && !hit_any) begin
                hit_any = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
        new_stride = acc_addr - ent_last[hit_idx];
        if (new_stride == ent_stride[hit_idx])
            conf_next = (ent_conf[hit_idx] == CONF_TOP) ? CONF_TOP : ent_conf[hit_idx] + 1'b1;
        else
            conf_next = '0;
    end

    assign stride_ok  = acc_valid && hit_any && (conf_next >= CONF_THR) && (new_stride != '0);
    assign stride_val = new_stride;
    assign any_conf   = |trust_vec;

    // Train the hit entry or allocate a new one round-robin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ent_valid[i]  <= 1'b0;
                ent_tag[i]    <= '0;
                ent_last[i]   <= '0;
                ent_stride[i] <= '0;
                ent_conf[i]   <= '0;
            end
            rr_ptr <= '0;
        end else if (acc_valid) begin
            if (hit_any) begin
                ent_last[hit_idx]   <= acc_addr;
                ent_stride[hit_idx] <= new_stride;
                ent_conf[hit_idx]   <= conf_next;
            end else begin
                ent_valid[rr_ptr]  <= 1'b1;
                ent_tag[rr_ptr]    <= acc_tag;
                ent_last[rr_ptr]   <= acc_addr;
                ent_stride[rr_ptr] <= '0;
                ent_conf[rr_ptr]   <= '0;
                rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pf_target_gen.sv
// Target generator: forms the stride or next-line target, aligns it and filters page crossings.
// Assumes: the stride input is the byte difference, modulo 2^AW.
module pf_target_gen
    import pf_pkg::*;
#(
    parameter int AW       = 32,
    parameter int LINE_W   = 6,
    parameter int PAGE_W   = 12,
    parameter int AHEAD_LG = 2
) (
    input  logic          acc_valid,
    input  logic [AW-1:0] acc_addr,
    input  logic          stride_ok,
    input  logic [AW-1:0] stride_val,
    input  logic          any_conf,
    output logic          req_valid,
    output logic [AW-1:0] req_addr
);
    localparam logic [AW-1:0] LINE_BYTES = AW'(1) << LINE_W;

    pf_kind_e      kind;
    logic [AW-1:0] raw_tgt;
    logic [AW-1:0] line_base;

    // Choose the request source and compute its aligned, page-checked target.
    always_comb begin
        line_base = {acc_addr[AW-1:LINE_W], {LINE_W{1'b0}}};
        if (!acc_valid)     kind = PFK_NONE;
        else if (stride_ok) kind = PFK_STRIDE;
        else if (!any_conf) kind = PFK_NEXT;
        else                kind = PFK_NONE;
        case (kind)
            PFK_STRIDE: raw_tgt = acc_addr + (stride_val << AHEAD_LG);
            default:    raw_tgt = line_base + LINE_BYTES;
        endcase
        req_addr  = {raw_tgt[AW-1:LINE_W], {LINE_W{1'b0}}};
        req_valid = (kind != PFK_NONE) && (req_addr[AW-1:PAGE_W] == acc_addr[AW-1:PAGE_W]);
    end
endmodule

// File: rtl/pf_req_fifo.sv
// Request queue: circular buffer that drops pushes while full.
// Assumes: DEPTH >= 2.
module pf_req_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push;
    logic             do_pop;

    assign out_valid = (count != '0);
    assign out_data  = mem[rd_ptr];
    assign do_push   = push && (count != CNT_W'(DEPTH));
    assign do_pop    = out_valid && pop_ready;

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    // Store accepted requests.
    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ptr] <= push_data;
    end
endmodule

// File: rtl/stride_prefetcher.sv
// Top: stride-detecting data prefetcher with next-line fallback and page filtering.
// Assumes: byte addresses, 64-byte lines, 4 KB pages, at most one demand per cycle.
module stride_prefetcher #(
    parameter int AW       = 32,
    parameter int LINE_W   = 6,
    parameter int PAGE_W   = 12,
    parameter int ENTRIES  = 4,
    parameter int CONF_W   = 2,
    parameter int CONF_MIN = 2,
    parameter int AHEAD_LG = 2,
    parameter int Q_DEPTH  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dmd_valid,
    input  logic [AW-1:0] dmd_addr,
    output logic          pf_valid,
    input  logic          pf_ready,
    output logic [AW-1:0] pf_addr
);
    logic          stride_ok;
    logic [AW-1:0] stride_val;
    logic          any_conf;
    logic          cand_valid;
    logic [AW-1:0] cand_addr;

    pf_stream_table #(
        .AW(AW), .PAGE_W(PAGE_W), .ENTRIES(ENTRIES),
        .CONF_W(CONF_W), .CONF_MIN(CONF_MIN)
    ) i_table (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(dmd_valid), .acc_addr(dmd_addr),
        .stride_ok(stride_ok), .stride_val(stride_val), .any_conf(any_conf)
    );

    pf_target_gen #(
        .AW(AW), .LINE_W(LINE_W), .PAGE_W(PAGE_W), .AHEAD_LG(AHEAD_LG)
    ) i_tgt (
        .acc_valid(dmd_valid), .acc_addr(dmd_addr),
        .stride_ok(stride_ok), .stride_val(stride_val), .any_conf(any_conf),
        .req_valid(cand_valid), .req_addr(cand_addr)
    );

    pf_req_fifo #(
        .W(AW), .DEPTH(Q_DEPTH)
    ) i_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(cand_valid), .push_data(cand_addr),
        .pop_ready(pf_ready),
        .out_valid(pf_valid), .out_data(pf_addr)
    );
endmodule

// File: rtl/pf_checker.sv
// Checker: temporal properties of the prefetcher, bound to the top.
// Assumes: push_en/push_addr are the candidate request from the target generator.
module pf_checker #(
    parameter int AW     = 32,
    parameter int LINE_W = 6,
    parameter int PAGE_W = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dmd_valid,
    input logic [AW-1:0] dmd_addr,
    input logic          pf_valid,
    input logic          pf_ready,
    input logic [AW-1:0] pf_addr,
    input logic          push_en,
    input logic [AW-1:0] push_addr
);
    p_line_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (pf_addr[LINE_W-1:0] == '0));

    p_same_page_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |-> (push_addr[AW-1:PAGE_W] == dmd_addr[AW-1:PAGE_W]));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));

    p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pf_valid && !push_en) |=> !pf_valid);

    p_demand_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !dmd_valid |-> !push_en);
endmodule

bind stride_prefetcher pf_checker #(.AW(AW), .LINE_W(LINE_W), .PAGE_W(PAGE_W)) i_pf_checker (
    .clk(clk), .rst_n(rst_n), .dmd_valid(dmd_valid), .dmd_addr(dmd_addr),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr),
    .push_en(cand_valid), .push_addr(cand_addr)
);

// File: tb/test_stride_prefetcher.sv
// Bench: vector table walk, then directed tests for reset, page edges, eviction and queue.
module test_stride_prefetcher;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 18;
    // Each vector: {access address, expect valid, expected pf address}
    localparam logic [64:0] VECS [NVEC] = '{
        {32'h0000_1000, 1'b1, 32'h0000_1040},
        {32'h0000_1200, 1'b1, 32'h0000_1240},
        {32'h0000_1400, 1'b1, 32'h0000_1440},
        {32'h0000_1600, 1'b1, 32'h0000_1E00},
        {32'h0000_1800, 1'b0, 32'h0000_0000},
        {32'h0000_8000, 1'b0, 32'h0000_0000},
        {32'h0000_8001, 1'b0, 32'h0000_0000},
        {32'h0000_8002, 1'b0, 32'h0000_0000},
        {32'h0000_8003, 1'b1, 32'h0000_8000},
        {32'h0000_3F00, 1'b0, 32'h0000_0000},
        {32'h0000_3EC0, 1'b0, 32'h0000_0000},
        {32'h0000_3E80, 1'b0, 32'h0000_0000},
        {32'h0000_3E40, 1'b1, 32'h0000_3D40},
        {32'h0000_8004, 1'b1, 32'h0000_8000},
        {32'h0000_8004, 1'b0, 32'h0000_0000},
        {32'h0000_8004, 1'b0, 32'h0000_0000},
        {32'h0000_8004, 1'b0, 32'h0000_0000},
        {32'h0000_8005, 1'b0, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dmd_valid = 1'b0;
    logic [31:0] dmd_addr = '0;
    logic        pf_valid;
    logic        pf_ready = 1'b0;
    logic [31:0] pf_addr;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    stride_prefetcher i_stride_prefetcher (
        .clk(clk), .rst_n(rst_n), .dmd_valid(dmd_valid), .dmd_addr(dmd_addr),
        .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
    );

    task automatic check(input logic ev, input logic [31:0] ea, input string tag);
        n_checks++;
        if (pf_valid !== ev || (ev && pf_addr !== ea)) begin
            n_fail++;
            $display("FAIL %s: actual valid=%0b addr=%h, expected valid=%0b addr=%h",
                     tag, pf_valid, pf_addr, ev, ea);
        end
    endtask

    // One accepted access; returns at the negedge after the capturing edge.
    task automatic send(input logic [31:0] a);
        @(negedge clk);
        dmd_valid = 1'b1;
        dmd_addr  = a;
        @(negedge clk);
        dmd_valid = 1'b0;
    endtask

    task automatic pop();
        pf_ready = 1'b1;
        @(negedge clk);
        pf_ready = 1'b0;
    endtask

    task automatic step(input logic [31:0] a, input logic ev, input logic [31:0] ea, input string tag);
        send(a);
        check(ev, ea, tag);
        if (pf_valid) pop();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(1'b0, '0, "R11 reset state");
        rst_n = 1'b1;

        // Table walk covering R2 R3 R4 R5 R6 R7 R8 R12
        for (int i = 0; i < NVEC; i++) begin
            step(VECS[i][64:33], VECS[i][32], VECS[i][31:0],
                 $sformatf("vector %0d (R2 R3 R4 R5 R6 R7 R8 R12)", i));
        end

        // R8: five page misses wrap the pointer and evict the trained page
        do_reset();
        step(32'h1000, 1'b1, 32'h1040, "R2 evict setup");
        step(32'h1200, 1'b1, 32'h1240, "R3 evict setup");
        step(32'h1400, 1'b1, 32'h1440, "R3 evict setup");
        step(32'h1600, 1'b1, 32'h1E00, "R4 evict setup");
        step(32'h2000, 1'b0, '0, "R6 alloc e1");
        step(32'h3000, 1'b0, '0, "R6 alloc e2");
        step(32'h4000, 1'b0, '0, "R6 alloc e3");
        step(32'h5000, 1'b0, '0, "R8 alloc e0 evicts");
        step(32'h1800, 1'b1, 32'h1840, "R8 evicted page retrains");

        // R11: reset drops queued request and trained streams
        do_reset();
        step(32'h6000, 1'b1, 32'h6040, "R2 pre-reset");
        step(32'h6040, 1'b1, 32'h6080, "R2 pre-reset");
        step(32'h6080, 1'b1, 32'h60C0, "R2 pre-reset");
        step(32'h60C0, 1'b1, 32'h61C0, "R4 pre-reset");
        send(32'h6100);
        check(1'b1, 32'h6200, "R4 queued before reset");
        do_reset();
        check(1'b0, '0, "R11 queue emptied");
        step(32'h6140, 1'b1, 32'h6180, "R11 table cleared");

        // R7: next-line at the page end
        do_reset();
        step(32'h1FC0, 1'b0, '0, "R7 next-line crosses page");
        step(32'h1F80, 1'b1, 32'h1FC0, "R2 next-line inside page");
        step(32'h2FFF, 1'b0, '0, "R7 unaligned access at page end");

        // R9 R10: queue overflow, hold, order, training while full
        do_reset();
        for (int k = 1; k <= 6; k++) send(32'(k) << 12);
        send(32'h7000);
        send(32'h7100);
        send(32'h7200);
        send(32'h7300);
        repeat (3) @(negedge clk);
        check(1'b1, 32'h1040, "R9 head holds while not ready");
        for (int k = 1; k <= 4; k++) begin
            check(1'b1, (32'(k) << 12) + 32'h40, $sformatf("R9 order %0d", k));
            pop();
        end
        check(1'b0, '0, "R9 overflow dropped");
        step(32'h7400, 1'b1, 32'h7800, "R10 trained while full");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule